// File: doc/BRIEF.md
# Handshake Transfer Controller with Timeout

This block moves parallel data words between two units that share no timing reference, using a two-wire handshake. It holds a sending state machine and a receiving state machine. Each one talks to an outside partner over its own data bus and two control lines. One mode input picks the protocol. In the sender-led protocol the sender raises a valid line and the receiver answers with an accept line. In the receiver-led protocol the receiver first raises a ready line and the sender answers with valid. Every step waits for the partner's answer for as long as it takes, so the slower party sets the rate.

Every control line from a partner passes through a two-flop synchronizer before a state machine acts on it. The receiver captures a word only on the rising edge of the synchronized valid line. Each side runs a wait counter that restarts at every handshake step. If a partner does not answer within a programmable number of cycles, the waiting side pulses an error, releases its control outputs and returns to idle.

Top module: `hs_xfer_ctrl`

## Requirements
- R1: During and right after reset, tx_valid, rx_reply, src_busy, src_done, src_tmo, dst_got and dst_tmo are 0, and tx_data and dst_word are all zeros.
- R2: With mode_dst_init = 0 (sender-led), a src_send pulse puts src_word on tx_data one cycle before tx_valid rises. tx_valid and tx_data then stay unchanged until the partner's accept (tx_reply = 1) is seen.
- R3: In sender-led mode, once accept is seen the sender drops tx_valid and drives tx_data to zero. It stays busy until tx_reply falls, then pulses src_done for one cycle as src_busy goes low.
- R4: With mode_dst_init = 1 (receiver-led), after src_send the sender keeps tx_valid low and tx_data at zero until ready (tx_reply = 1) is seen. It then drives the word for one cycle and raises tx_valid. When ready falls it drops tx_valid, zeroes tx_data and pulses src_done.
- R5: In sender-led mode, the receiver captures rx_data into dst_word on a rising rx_valid, pulses dst_got and raises rx_reply (accept). It holds rx_reply until rx_valid falls.
- R6: In receiver-led mode, a dst_want pulse raises rx_reply (ready). On a rising rx_valid the receiver captures the word, pulses dst_got and drops rx_reply. It only starts a new transfer after rx_valid has fallen.
- R7: A word is captured only on a low-to-high change of rx_valid. An rx_valid that is already high, or stays high, causes no capture, and changes of rx_data during it leave dst_word unchanged.
- R8: A change on tx_reply or rx_valid, applied between clock edges, changes the state machine's outputs on the third rising edge after it and not earlier.
- R9: With tmo_limit = L > 0, a side that spends L+1 cycles in one waiting step without the partner's answer returns to idle with its control output low. It pulses its timeout output (src_tmo or dst_tmo) for one cycle, never together with src_done.
- R10: The wait counter restarts at every handshake step, so a transfer whose total length exceeds L+1 cycles completes without a timeout as long as no single step does.
- R11: tmo_limit = 0 disables the timeout: a side may wait forever.
- R12: With tx_valid/tx_data connected to rx_valid/rx_data and rx_reply to tx_reply, each word sent arrives unchanged in dst_word in either mode, with one src_done and one dst_got per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dst_init | input | 1 | 0 = sender-led, 1 = receiver-led; taken when a transfer starts |
| tmo_limit | input | CW | Wait limit in cycles per step; 0 disables the timeout |
| src_send | input | 1 | Start a send of src_word (ignored while busy) |
| src_word | input | W | Word to send |
| src_busy | output | 1 | Sender is in a transfer |
| src_done | output | 1 | One-cycle pulse: send completed |
| src_tmo | output | 1 | One-cycle pulse: sender gave up waiting |
| tx_data | output | W | Data bus toward the partner; zero when not driven |
| tx_valid | output | 1 | Data-valid toward the partner |
| tx_reply | input | 1 | Partner's accept (sender-led) or ready (receiver-led) |
| dst_want | input | 1 | Request one word (receiver-led mode only) |
| dst_word | output | W | Last captured word |
| dst_got | output | 1 | One-cycle pulse: word captured |
| dst_tmo | output | 1 | One-cycle pulse: receiver gave up waiting |
| rx_data | input | W | Data bus from the partner |
| rx_valid | input | 1 | Data-valid from the partner |
| rx_reply | output | 1 | Accept (sender-led) or ready (receiver-led) toward the partner |

## Verification
A corrupted state in either machine shows at the ports within one cycle, since tx_valid, tx_data and rx_reply decode straight from the state register. A misplaced word shows as tx_data changing while tx_valid is high, or as a wrong dst_word on the dst_got pulse. A wrong wait counter shows as a timeout pulse one or more cycles off the expected L+1 count, or as a timeout in a transfer whose steps are each short. A wrong synchronizer depth shifts every reaction away from the third edge after the partner's change.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WRDY  = 3'd1,
        S_LOAD  = 3'd2,
        S_VALID = 3'd3,
        S_REL   = 3'd4
    } src_state_e;

    typedef enum logic [1:0] {
        D_IDLE  = 2'd0,
        D_READY = 2'd1,
        D_ACC   = 2'd2,
        D_DRAIN = 2'd3
    } dst_state_e;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/hs_src_fsm.sv
module hs_src_fsm
    import hs_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic [CW-1:0] limit_i,
    input  logic          send_i,
    input  logic [W-1:0]  word_i,
    input  logic          reply_s,
    output logic          busy_o,
    output logic          done_o,
    output logic          tmo_o,
    output logic [W-1:0]  tx_data_o,
    output logic          tx_valid_o
);
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        src_state_e    st;
        logic          mode;
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
        logic          done;
        logic          tmo;
    } src_reg_t;

    src_reg_t q, d;
    logic waiting, advance, expired;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.tmo   = 1'b0;
        waiting = 1'b0;
        advance = 1'b0;
        unique case (q.st)
            S_IDLE: if (send_i) begin
                d.word  = word_i;
                d.mode  = mode_i;
                d.st    = mode_i ? S_WRDY : S_LOAD;
                advance = 1'b1;
            end
            S_WRDY: begin
                waiting = 1'b1;
                if (reply_s) begin
                    d.st    = S_LOAD;
                    advance = 1'b1;
                end
            end
            S_LOAD: begin
                d.st    = S_VALID;
                advance = 1'b1;
            end
            S_VALID: begin
                waiting = 1'b1;
                if (q.mode ? !reply_s : reply_s) begin
                    advance = 1'b1;
                    d.st    = q.mode ? S_IDLE : S_REL;
                    d.done  = q.mode;
                end
            end
            S_REL: begin
                waiting = 1'b1;
                if (!reply_s) begin
                    advance = 1'b1;
                    d.st    = S_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
        expired = waiting && !advance && (limit_i != '0) && (q.cnt >= limit_i);
        if (expired) begin
            d.st  = S_IDLE;
            d.tmo = 1'b1;
        end
        if (advance || !waiting || expired) d.cnt = '0;
        else if (q.cnt != CNT_MAX)          d.cnt = q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, mode: 1'b0, word: '0, cnt: '0, done: 1'b0, tmo: 1'b0};
        else        q <= d;
    end

    assign tx_valid_o = (q.st == S_VALID);
    assign tx_data_o  = (q.st == S_LOAD || q.st == S_VALID) ? q.word : '0;
    assign busy_o     = (q.st != S_IDLE);
    assign done_o     = q.done;
    assign tmo_o      = q.tmo;

    // R2: the word is already on the bus in the cycle before valid rises
    assert_data_before_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> $stable(tx_data_o));
    // R2: the bus holds still while valid stays high
    assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && $past(tx_valid_o)) |-> $stable(tx_data_o));
    // R4: in receiver-led mode valid rises only after ready was seen
    assert_valid_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_valid_o) && q.mode) |-> $past(reply_s, 2));
    // R9: a timeout is a single-cycle pulse
    assert_tmo_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> !tmo_o);
    // R9: a send never both completes and times out
    assert_done_tmo_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && tmo_o));
endmodule

// File: rtl/hs_dst_fsm.sv
module hs_dst_fsm
    import hs_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic [CW-1:0] limit_i,
    input  logic          want_i,
    input  logic [W-1:0]  rx_data_i,
    input  logic          valid_s,
    output logic [W-1:0]  word_o,
    output logic          got_o,
    output logic          tmo_o,
    output logic          rx_reply_o
);
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        dst_state_e    st;
        logic          mode;
        logic [W-1:0]  word;
        logic [CW-1:0] cnt;
        logic          vprev;
        logic          got;
        logic          tmo;
    } dst_reg_t;

    dst_reg_t q, d;
    logic waiting, advance, expired, rise;

    always_comb begin
        d       = q;
        d.got   = 1'b0;
        d.tmo   = 1'b0;
        d.vprev = valid_s;
        rise    = valid_s && !q.vprev;
        waiting = 1'b0;
        advance = 1'b0;
        unique case (q.st)
            D_IDLE: begin
                if (mode_i) begin
                    if (want_i) begin
                        d.st    = D_READY;
                        d.mode  = 1'b1;
                        advance = 1'b1;
                    end
                end else if (rise) begin
                    d.word  = rx_data_i;
                    d.got   = 1'b1;
                    d.st    = D_ACC;
                    d.mode  = 1'b0;
                    advance = 1'b1;
                end
            end
            D_READY: begin
                waiting = 1'b1;
                if (rise) begin
                    d.word  = rx_data_i;
                    d.got   = 1'b1;
                    d.st    = D_DRAIN;
                    advance = 1'b1;
                end
            end
            D_ACC, D_DRAIN: begin
                waiting = 1'b1;
                if (!valid_s) begin
                    d.st    = D_IDLE;
                    advance = 1'b1;
                end
            end
            default: d.st = D_IDLE;
        endcase
        expired = waiting && !advance && (limit_i != '0) && (q.cnt >= limit_i);
        if (expired) begin
            d.st  = D_IDLE;
            d.tmo = 1'b1;
        end
        if (advance || !waiting || expired) d.cnt = '0;
        else if (q.cnt != CNT_MAX)          d.cnt = q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: D_IDLE, mode: 1'b0, word: '0, cnt: '0, vprev: 1'b0, got: 1'b0, tmo: 1'b0};
        else        q <= d;
    end

    assign rx_reply_o = (q.st == D_READY) || (q.st == D_ACC);
    assign word_o     = q.word;
    assign got_o      = q.got;
    assign tmo_o      = q.tmo;

    // R7: a capture follows a low-to-high change of the synchronized valid
    assert_capture_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        got_o |-> ($past(valid_s) && !$past(q.vprev)));
    // R6: in receiver-led mode ready is down once the word is taken
    assert_ready_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (got_o && q.mode) |-> !rx_reply_o);
    // R9: a timeout is a single-cycle pulse, never with a capture
    assert_tmo_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> (!tmo_o && !got_o));
endmodule

// File: rtl/hs_xfer_ctrl.sv
module hs_xfer_ctrl #(
    parameter int W      = 8,
    parameter int CW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_dst_init,
    input  logic [CW-1:0] tmo_limit,
    input  logic          src_send,
    input  logic [W-1:0]  src_word,
    output logic          src_busy,
    output logic          src_done,
    output logic          src_tmo,
    output logic [W-1:0]  tx_data,
    output logic          tx_valid,
    input  logic          tx_reply,
    input  logic          dst_want,
    output logic [W-1:0]  dst_word,
    output logic          dst_got,
    output logic          dst_tmo,
    input  logic [W-1:0]  rx_data,
    input  logic          rx_valid,
    output logic          rx_reply
);
    logic reply_s, valid_s;

    hs_sync2 #(.STAGES(STAGES)) u_sync_reply (
        .clk(clk), .rst_n(rst_n), .d_i(tx_reply), .q_o(reply_s));

    hs_sync2 #(.STAGES(STAGES)) u_sync_valid (
        .clk(clk), .rst_n(rst_n), .d_i(rx_valid), .q_o(valid_s));

    hs_src_fsm #(.W(W), .CW(CW)) u_src (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_dst_init), .limit_i(tmo_limit),
        .send_i(src_send), .word_i(src_word), .reply_s(reply_s),
        .busy_o(src_busy), .done_o(src_done), .tmo_o(src_tmo),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid));

    hs_dst_fsm #(.W(W), .CW(CW)) u_dst (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_dst_init), .limit_i(tmo_limit),
        .want_i(dst_want), .rx_data_i(rx_data), .valid_s(valid_s),
        .word_o(dst_word), .got_o(dst_got), .tmo_o(dst_tmo), .rx_reply_o(rx_reply));
endmodule

// File: tb/tb_hs_xfer_ctrl.sv
module tb_hs_xfer_ctrl;
    localparam int W  = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0, s_send = 1'b0, b_ack = 1'b0, d_want = 1'b0, b_valid = 1'b0, loopback = 1'b0;
    logic [CW-1:0] limit = '0;
    logic [W-1:0]  s_word = '0, b_data = '0;

    logic src_busy, src_done, src_tmo, tx_valid, dst_got, dst_tmo, rx_reply;
    logic [W-1:0] tx_data, dst_word;
    logic tx_reply_w, rx_valid_w;
    logic [W-1:0] rx_data_w;

    assign tx_reply_w = loopback ? rx_reply : b_ack;
    assign rx_valid_w = loopback ? tx_valid : b_valid;
    assign rx_data_w  = loopback ? tx_data  : b_data;

    hs_xfer_ctrl #(.W(W), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_dst_init(mode), .tmo_limit(limit),
        .src_send(s_send), .src_word(s_word), .src_busy(src_busy),
        .src_done(src_done), .src_tmo(src_tmo), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_reply(tx_reply_w), .dst_want(d_want),
        .dst_word(dst_word), .dst_got(dst_got), .dst_tmo(dst_tmo),
        .rx_data(rx_data_w), .rx_valid(rx_valid_w), .rx_reply(rx_reply));

    always #10 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int n_done = 0, n_stmo = 0, n_got = 0, n_dtmo = 0;

    always @(posedge clk) begin
        if (src_done) n_done++;
        if (src_tmo)  n_stmo++;
        if (dst_got)  n_got++;
        if (dst_tmo)  n_dtmo++;
    end

    // bit 8 = mode, bits 7:0 = word; the expected received word is the low byte
    localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h100, 9'h0FF, 9'h15C, 9'h181, 9'h000};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int d0, t0, g0, n;
        tick(3);
        check(!tx_valid && !rx_reply && !src_busy && !src_done && !dst_got && tx_data == 0 && dst_word == 0,
              "R1 in reset", {tx_valid, rx_reply, src_busy}, 0);
        rst_n = 1'b1;
        tick(1);
        check(!tx_valid && !rx_reply && !src_busy && !src_tmo && !dst_tmo && tx_data == 0,
              "R1 after reset", {tx_valid, rx_reply, src_busy, src_tmo, dst_tmo}, 0);

        // R12: table of loopback transfers
        loopback = 1'b1; limit = 8'd20;
        foreach (VEC[i]) begin
            mode = VEC[i][8]; s_word = VEC[i][7:0];
            d0 = n_done; g0 = n_got; t0 = n_stmo + n_dtmo;
            tick(1);
            s_send = 1'b1; d_want = mode;
            tick(1);
            s_send = 1'b0; d_want = 1'b0;
            for (int k = 0; k < 60; k++) begin
                tick(1);
                if (n_done != d0 && n_got != g0 && !src_busy) break;
            end
            tick(6);
            check(dst_word == VEC[i][7:0] && n_done == d0 + 1 && n_got == g0 + 1 && n_stmo + n_dtmo == t0,
                  "R12 loopback word", dst_word, VEC[i][7:0]);
        end
        loopback = 1'b0; limit = 0;

        // R2/R3/R8: sender-led send
        mode = 1'b0; s_word = 8'hA5; s_send = 1'b1;
        tick(1); s_send = 1'b0;
        check(tx_data == 8'hA5 && !tx_valid, "R2 data before valid", {tx_valid, tx_data}, 9'h0A5);
        tick(1);
        check(tx_data == 8'hA5 && tx_valid, "R2 valid raised", {tx_valid, tx_data}, 9'h1A5);
        n = 0;
        for (int k = 0; k < 4; k++) begin tick(1); if (tx_valid && tx_data == 8'hA5) n++; end
        check(n == 4, "R2 valid held without accept", n, 4);
        b_ack = 1'b1;
        tick(1); n = tx_valid;
        tick(1); n += tx_valid;
        check(n == 2, "R8 valid held two cycles after accept", n, 2);
        tick(1);
        check(!tx_valid && tx_data == 0 && src_busy && !src_done, "R3 release after accept",
              {tx_valid, src_busy, src_done, tx_data}, 11'h200);
        tick(3);
        check(src_busy && !tx_valid, "R3 busy until accept falls", src_busy, 1);
        b_ack = 1'b0;
        tick(2);
        check(src_busy && !src_done, "R8 done not early", {src_busy, src_done}, 2'b10);
        tick(1);
        check(src_done && !src_busy, "R3 done pulse", {src_busy, src_done}, 2'b01);
        tick(1);
        check(!src_done, "R3 done one cycle", src_done, 0);

        // R4: receiver-led send
        mode = 1'b1; s_word = 8'h3C; s_send = 1'b1;
        tick(1); s_send = 1'b0;
        n = 0;
        for (int k = 0; k < 10; k++) begin tick(1); if (!tx_valid && tx_data == 0 && src_busy) n++; end
        check(n == 10, "R4 nothing driven before ready", n, 10);
        b_ack = 1'b1;
        tick(3);
        check(tx_data == 8'h3C && !tx_valid, "R4 data after ready", {tx_valid, tx_data}, 9'h03C);
        tick(1);
        check(tx_data == 8'h3C && tx_valid, "R4 valid after data", {tx_valid, tx_data}, 9'h13C);
        tick(2);
        b_ack = 1'b0;
        tick(3);
        check(!tx_valid && tx_data == 0 && src_done && !src_busy, "R4 release on ready low",
              {tx_valid, src_done, src_busy, tx_data}, 11'h200);

        // R5/R7: sender-led receive
        mode = 1'b0; b_data = 8'h5A; b_valid = 1'b1;
        tick(3);
        check(dst_got && dst_word == 8'h5A && rx_reply, "R5 capture and accept", {dst_got, rx_reply, dst_word}, 10'h35A);
        b_data = 8'hFF;
        tick(1);
        check(!dst_got && rx_reply, "R5 accept held", {dst_got, rx_reply}, 2'b01);
        tick(3);
        check(dst_word == 8'h5A && rx_reply, "R7 held valid no recapture", dst_word, 8'h5A);
        b_valid = 1'b0;
        tick(3);
        check(!rx_reply, "R5 accept drops after valid", rx_reply, 0);

        // R6: receiver-led receive
        mode = 1'b1; d_want = 1'b1;
        tick(1); d_want = 1'b0;
        check(rx_reply, "R6 ready raised", rx_reply, 1);
        tick(2);
        b_data = 8'h77; b_valid = 1'b1;
        tick(3);
        check(dst_got && dst_word == 8'h77 && !rx_reply, "R6 capture drops ready", {dst_got, rx_reply, dst_word}, 10'h277);
        tick(2);
        b_valid = 1'b0;
        tick(4);

        // R7: valid already high when ready is raised
        limit = 8'd8; b_data = 8'h11; b_valid = 1'b1;
        tick(4);
        g0 = n_got; t0 = n_dtmo;
        d_want = 1'b1; tick(1); d_want = 1'b0;
        tick(14);
        check(n_got == g0 && dst_word == 8'h77 && n_dtmo == t0 + 1 && !rx_reply,
              "R7 held valid not captured", dst_word, 8'h77);
        b_valid = 1'b0; tick(4);

        // R9: sender timeout
        mode = 1'b0; limit = 8'd5; s_word = 8'hC3; s_send = 1'b1;
        tick(1); s_send = 1'b0;
        n = 0;
        for (int k = 0; k < 40; k++) begin tick(1); if (src_tmo) break; if (tx_valid) n++; end
        check(n == 6, "R9 sender waits L+1 cycles", n, 6);
        check(src_tmo && !tx_valid && tx_data == 0 && !src_busy, "R9 sender released",
              {src_tmo, tx_valid, src_busy}, 3'b100);
        tick(1);
        check(!src_tmo, "R9 timeout one cycle", src_tmo, 0);

        // R9: receiver timeout
        limit = 8'd4; b_data = 8'h42; b_valid = 1'b1;
        n = 0;
        for (int k = 0; k < 40; k++) begin tick(1); if (dst_tmo) break; if (rx_reply) n++; end
        check(n == 5 && !rx_reply, "R9 receiver waits L+1 cycles", n, 5);
        b_valid = 1'b0; tick(4);

        // R10: long transfer, short steps
        limit = 8'd6; t0 = n_stmo; d0 = n_done; s_send = 1'b1;
        tick(1); s_send = 1'b0;
        tick(1);
        tick(3); b_ack = 1'b1;
        tick(5); b_ack = 1'b0;
        tick(3);
        check(src_done && n_stmo == t0, "R10 counter restarts per step", n_stmo - t0, 0);

        // R11: limit zero never times out
        limit = 0; t0 = n_stmo; s_send = 1'b1;
        tick(1); s_send = 1'b0;
        tick(300);
        check(tx_valid && n_stmo == t0, "R11 no timeout when disabled", tx_valid, 1);
        b_ack = 1'b1; tick(4); b_ack = 1'b0; tick(4);
        check(!src_busy, "R11 completes after long wait", src_busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule